// File: doc/BRIEF.md
# Phase-Lock Loss Detector with Hold-Off Stretch

This block watches the phase-error pulses that a phase-frequency comparator emits once per comparison cycle (one pulse on the "up" line when the divided oscillator lags, one on the "down" line when it leads). It runs from the crystal reference clock and drives a single active-low flag that reads low while the loop is judged out of lock.

A two-bit mode input picks how the flag is formed. In the stopped mode the flag is released high. In the pass-through mode the flag is the inverted, registered phase error, so any pulse shows up directly. The two threshold modes measure each error pulse in reference-clock cycles. A pulse longer than the selected limit pulls the flag low, and the flag stays low for a fixed hold-off time after the last over-limit sample. The oscillator-select input rescales both the width limits and the hold-off time, so that they keep the same duration whichever of the two crystal frequencies is fitted.

Top module: `ulk_unlock_det`

## Requirements
- R1: While rst_n is low, unlock_n_o is 1 for every mode and error input. After the reset is released, unlock_n_o stays 1 as long as mode_i is 00 or no error pulse has arrived.
- R2: With mode_i = 00 (stopped), unlock_n_o is 1 in the same cycle, whatever up_i and dn_i do.
- R3: With mode_i = 01 (pass-through), unlock_n_o after a clock edge equals NOT(up_i OR dn_i) as sampled at that edge.
- R4: With mode_i = 10 and xsel_i = 1, an error pulse of at most 4 consecutive high samples leaves unlock_n_o high. A longer pulse drives unlock_n_o low right after the edge that takes the 5th consecutive high sample.
- R5: With mode_i = 11 and xsel_i = 1, the limit is 8 samples: 8 leaves the flag high, and the flag falls after the edge that takes the 9th sample.
- R6: With xsel_i = 0 (slower crystal), the limits are 3 samples for mode 10 and 5 samples for mode 11, with the same fall rule as R4.
- R7: In a threshold mode, unlock_n_o returns to 1 exactly EXT clock edges after the last edge at which an over-limit sample was taken. EXT is EXT_FAST for xsel_i = 1 and EXT_SLOW for xsel_i = 0.
- R8: A new over-limit pulse during the hold-off restarts the full hold-off. A pulse within the limit does not extend it.
- R9: A pulse on dn_i is measured exactly like a pulse on up_i. The measured width is the run of consecutive samples with up_i OR dn_i high.
- R10: Leaving the threshold modes clears the hold-off. When a threshold mode is entered again, unlock_n_o starts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_i | input | 1 | Phase-error pulse, oscillator lagging |
| dn_i | input | 1 | Phase-error pulse, oscillator leading |
| mode_i | input | 2 | 00 stopped, 01 pass-through, 10 narrow limit, 11 wide limit |
| xsel_i | input | 1 | Crystal select: 1 faster crystal, 0 slower crystal |
| unlock_n_o | output | 1 | Out-of-lock flag, low when unlocked |

## Verification
Single pulses are swept across each limit: one sample at the limit and one sample past it, for both crystal selections and both threshold modes. This separates an off-by-one in the width count from a wrong threshold table entry. The same pulse is driven on the down line to show that both error directions are measured alike. Long pulses show that the hold-off is counted from the last over-limit sample rather than from the first. Two-pulse patterns separate a restarting hold-off from one that only runs once, and show that a short second pulse does not re-arm it. Mode switches are used to show that the stopped and pass-through paths are taken at once and that a stale hold-off is not carried back into a threshold mode.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RAW    = 2'b01,
    MODE_NARROW = 2'b10,
    MODE_WIDE   = 2'b11
  } ulk_mode_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..v
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ulk_rst_sync.sv
module ulk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stage_d[i] = 1'b1;
      end else begin : g_next
        assign stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/ulk_limit_sel.sv
module ulk_limit_sel #(
  parameter int unsigned THR_NARROW_FAST = 4,
  parameter int unsigned THR_WIDE_FAST   = 8,
  parameter int unsigned THR_NARROW_SLOW = 3,
  parameter int unsigned THR_WIDE_SLOW   = 5,
  parameter int unsigned EXT_FAST        = 10800,
  parameter int unsigned EXT_SLOW        = 6750,
  parameter int unsigned CW              = 4,
  parameter int unsigned TW              = 14
) (
  input  logic          wide_i,
  input  logic          xsel_i,
  output logic [CW-1:0] thr_o,
  output logic [TW-1:0] ext_o
);

  always_comb begin
    unique case ({xsel_i, wide_i})
      2'b00:   thr_o = CW'(THR_NARROW_SLOW);
      2'b01:   thr_o = CW'(THR_WIDE_SLOW);
      2'b10:   thr_o = CW'(THR_NARROW_FAST);
      default: thr_o = CW'(THR_WIDE_FAST);
    endcase
  end

  assign ext_o = xsel_i ? TW'(EXT_FAST) : TW'(EXT_SLOW);

endmodule

// File: rtl/ulk_width_meter.sv
module ulk_width_meter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          err_i,
  input  logic [CW-1:0] thr_i,
  output logic          over_o
);

  localparam logic [CW-1:0] CNT_SAT = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // run length of the error pulse, saturating, zero between pulses
  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || !err_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_SAT) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // this sample is past the limit when thr samples are already counted
  assign over_o = en_i && err_i && (cnt_q >= thr_i);

endmodule

// File: rtl/ulk_stretch.sv
module ulk_stretch #(
  parameter int unsigned TW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic [TW-1:0] len_i,
  output logic          hold_o
);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] tmr_d;
  logic          tmr_run;

  assign tmr_run = (tmr_q != '0);

  always_comb begin
    tmr_d = tmr_q;
    if (!en_i) begin
      tmr_d = '0;
    end else if (trig_i) begin
      tmr_d = len_i;
    end else if (tmr_run) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign hold_o = tmr_run;

endmodule

// File: rtl/ulk_unlock_det.sv
module ulk_unlock_det
  import ulk_pkg::*;
#(
  parameter int unsigned THR_NARROW_FAST = 4,
  parameter int unsigned THR_WIDE_FAST   = 8,
  parameter int unsigned THR_NARROW_SLOW = 3,
  parameter int unsigned THR_WIDE_SLOW   = 5,
  parameter int unsigned EXT_FAST        = 10800,
  parameter int unsigned EXT_SLOW        = 6750,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic [1:0] mode_i,
  input  logic       xsel_i,
  output logic       unlock_n_o
);

  localparam int unsigned THR_MAX = umax(umax(THR_NARROW_FAST, THR_WIDE_FAST),
                                         umax(THR_NARROW_SLOW, THR_WIDE_SLOW));
  localparam int unsigned CW      = bits_for(THR_MAX + 1);
  localparam int unsigned EXT_MAX = umax(EXT_FAST, EXT_SLOW);
  localparam int unsigned TW      = bits_for(EXT_MAX);

  ulk_mode_e     mode;
  logic          rst_core_n;
  logic          err_raw;
  logic          det_active;
  logic [CW-1:0] thr_sel;
  logic [TW-1:0] ext_sel;
  logic          over_evt;
  logic          hold;
  logic          err_q;
  logic          err_d;

  assign mode       = ulk_mode_e'(mode_i);
  assign err_raw    = up_i | dn_i;
  assign det_active = (mode == MODE_NARROW) || (mode == MODE_WIDE);

  ulk_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  ulk_limit_sel #(
    .THR_NARROW_FAST(THR_NARROW_FAST),
    .THR_WIDE_FAST  (THR_WIDE_FAST),
    .THR_NARROW_SLOW(THR_NARROW_SLOW),
    .THR_WIDE_SLOW  (THR_WIDE_SLOW),
    .EXT_FAST       (EXT_FAST),
    .EXT_SLOW       (EXT_SLOW),
    .CW             (CW),
    .TW             (TW)
  ) u_sel (
    .wide_i(mode == MODE_WIDE),
    .xsel_i(xsel_i),
    .thr_o (thr_sel),
    .ext_o (ext_sel)
  );

  ulk_width_meter #(
    .CW(CW)
  ) u_meter (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en_i  (det_active),
    .err_i (err_raw),
    .thr_i (thr_sel),
    .over_o(over_evt)
  );

  ulk_stretch #(
    .TW(TW)
  ) u_stretch (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en_i  (det_active),
    .trig_i(over_evt),
    .len_i (ext_sel),
    .hold_o(hold)
  );

  // registered copy of the raw error for the pass-through mode
  assign err_d = err_raw;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  always_comb begin
    unique case (mode)
      MODE_OFF: unlock_n_o = 1'b1;
      MODE_RAW: unlock_n_o = ~err_q;
      default:  unlock_n_o = ~hold;
    endcase
  end

endmodule

// File: rtl/ulk_unlock_det_chk.sv
module ulk_unlock_det_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic [1:0] mode_i,
  input logic       up_i,
  input logic       dn_i,
  input logic       unlock_n_o,
  input logic       over_evt
);

  p_stopped_high_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i == 2'b00) |-> unlock_n_o);

  p_raw_follow_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((mode_i == 2'b01) && $past(rst_core_n)) |-> (unlock_n_o == !$past(up_i || dn_i)));

  p_over_pulls_low_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (over_evt && mode_i[1]) |=> (!mode_i[1] || !unlock_n_o));

  p_release_after_quiet_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($rose(unlock_n_o) && mode_i[1] && $past(mode_i[1])) |-> !$past(over_evt));

  p_fall_needs_error_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($fell(unlock_n_o) && mode_i[1] && $past(mode_i[1])) |-> $past(up_i || dn_i));

  p_enter_released_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i[1] && !$past(mode_i[1])) |-> unlock_n_o);

endmodule

bind ulk_unlock_det ulk_unlock_det_chk u_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .mode_i    (mode_i),
  .up_i      (up_i),
  .dn_i      (dn_i),
  .unlock_n_o(unlock_n_o),
  .over_evt  (over_evt)
);

// File: tb/sim_ulk_unlock_det.sv
`timescale 1ns/1ps
module sim_ulk_unlock_det;

  localparam int EXT_F = 40;
  localparam int EXT_S = 24;
  localparam int WIN   = 90;

  logic       clk;
  logic       rst_n;
  logic       up_i;
  logic       dn_i;
  logic [1:0] mode_i;
  logic       xsel_i;
  logic       unlock_n_o;

  int checks;
  int failures;

  ulk_unlock_det #(
    .EXT_FAST(EXT_F),
    .EXT_SLOW(EXT_S)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .mode_i    (mode_i),
    .xsel_i    (xsel_i),
    .unlock_n_o(unlock_n_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    up_i = 1'b0;
    dn_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse A covers samples 1..wa, pulse B covers sb..sb+wb-1.
  // Sample k is taken at edge k; the output seen after edge k is recorded.
  task automatic run_case(input string req, input logic [1:0] md, input logic xs,
                          input int wa, input bit dna, input int sb, input int wb,
                          input bit dnb, input int exp_fall, input int exp_rise);
    int fall_idx;
    int rise_idx;
    bit a_on;
    bit b_on;
    fall_idx = 0;
    rise_idx = 0;
    mode_i = md;
    xsel_i = xs;
    idle(60);
    for (int k = 1; k <= WIN + 1; k++) begin
      if (k > 1) begin
        if (unlock_n_o == 1'b0 && fall_idx == 0) fall_idx = k - 1;
        if (unlock_n_o == 1'b1 && fall_idx != 0 && rise_idx == 0) rise_idx = k - 1;
      end
      a_on = (k <= wa);
      b_on = (wb > 0) && (k >= sb) && (k < sb + wb);
      up_i = (a_on && !dna) || (b_on && !dnb);
      dn_i = (a_on && dna) || (b_on && dnb);
      @(negedge clk);
    end
    check({req, " fall"}, fall_idx, exp_fall);
    check({req, " rise"}, rise_idx, exp_rise);
    idle(2);
  endtask

  task automatic test_reset();
    rst_n  = 1'b0;
    mode_i = 2'b10;
    xsel_i = 1'b1;
    up_i   = 1'b1;
    dn_i   = 1'b0;
    repeat (12) @(negedge clk);
    check("R1 in reset", unlock_n_o, 1);
    up_i   = 1'b0;
    mode_i = 2'b00;
    rst_n  = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after reset", unlock_n_o, 1);
  endtask

  task automatic test_mode_switch();
    mode_i = 2'b10;
    xsel_i = 1'b1;
    idle(60);
    up_i = 1'b1;
    repeat (6) @(negedge clk);
    up_i = 1'b0;
    @(negedge clk);
    check("R10 low before switch", unlock_n_o, 0);
    mode_i = 2'b00;
    #1;
    check("R2 stopped releases at once", unlock_n_o, 1);
    repeat (2) @(negedge clk);
    mode_i = 2'b10;
    #1;
    check("R10 re-entry released", unlock_n_o, 1);
    @(negedge clk);
    check("R10 stays released", unlock_n_o, 1);
    idle(2);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    test_reset();
    run_case("R2 stopped mode",        2'b00, 1'b1, 20, 1'b0, 0, 0, 1'b0, 0, 0);
    run_case("R3 raw up",              2'b01, 1'b1, 3,  1'b0, 0, 0, 1'b0, 1, 4);
    run_case("R3 raw dn",              2'b01, 1'b1, 1,  1'b1, 0, 0, 1'b0, 1, 2);
    run_case("R4 narrow at limit",     2'b10, 1'b1, 4,  1'b0, 0, 0, 1'b0, 0, 0);
    run_case("R4 R7 narrow over",      2'b10, 1'b1, 5,  1'b0, 0, 0, 1'b0, 5, 5 + EXT_F);
    run_case("R9 narrow over on dn",   2'b10, 1'b1, 5,  1'b1, 0, 0, 1'b0, 5, 5 + EXT_F);
    run_case("R7 long pulse",          2'b10, 1'b1, 12, 1'b0, 0, 0, 1'b0, 5, 12 + EXT_F);
    run_case("R5 wide at limit",       2'b11, 1'b1, 8,  1'b0, 0, 0, 1'b0, 0, 0);
    run_case("R5 wide over",           2'b11, 1'b1, 9,  1'b0, 0, 0, 1'b0, 9, 9 + EXT_F);
    run_case("R6 slow narrow at limit",2'b10, 1'b0, 3,  1'b0, 0, 0, 1'b0, 0, 0);
    run_case("R6 R7 slow narrow over", 2'b10, 1'b0, 4,  1'b0, 0, 0, 1'b0, 4, 4 + EXT_S);
    run_case("R6 slow wide at limit",  2'b11, 1'b0, 5,  1'b1, 0, 0, 1'b0, 0, 0);
    run_case("R6 slow wide over",      2'b11, 1'b0, 6,  1'b1, 0, 0, 1'b0, 6, 6 + EXT_S);
    run_case("R8 retrigger",           2'b10, 1'b1, 6,  1'b0, 20, 6, 1'b1, 5, 25 + EXT_F);
    run_case("R8 short no retrigger",  2'b10, 1'b1, 6,  1'b0, 20, 4, 1'b1, 5, 6 + EXT_F);
    test_mode_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule